// File: doc/BRIEF.md
# Recirculating Linear CORDIC Quotient Pipeline

The block approximates the quotient of two signed fixed-point numbers with linear-mode CORDIC iterations, one iteration per processing stage. Words arrive on a single input stream. A word flagged as control carries a starting step size in its X field. A data word carries the three working values: X holds the divisor, Y holds the dividend, and Z holds the partial quotient, which starts at zero. Each stage looks at the sign of Y and decides which way to step. It then moves Y by X times the step size and moves Z by the step size in the opposite direction. X passes through unchanged.

The step size is a register in every stage. It is not a constant. A control word loads the first stage, and each later stage takes half of its neighbour's value as the control word travels down the pipeline. Data behind the control word therefore sees the new schedule, and data ahead of it keeps the old one.

An external controller can chain passes to run any number of iterations. It feeds a pass's X, Y and Z outputs back in as new data, sending first a control word whose step size continues the schedule. Z then settles toward b/a. All values are 32-bit two's complement with 24 fraction bits, so 1.0 is 0x0100_0000.

Top module: `cordic_div_pipe`

## Requirements
- R1: After reset, out_valid is low, and stage k (k = 0 .. NUM_PE-1) uses a step size of 1.0 shifted right by k until the first control word arrives.
- R2: An input word with in_valid and in_ctrl both high loads in_x as the step size of stage 0. Stage k then uses that value arithmetically shifted right by k bits. The new values apply to every data word that enters after the control word.
- R3: A data word that enters before a control word uses the old step sizes in every stage, even though the control word follows it through the pipeline. Step sizes change only when a control word passes.
- R4: Per stage, with step C: prod = (X*C) arithmetically shifted right by 24, truncated to 32 bits. If Y is negative (bit 31 set), Y becomes Y+prod and Z becomes Z-C. Otherwise Y becomes Y-prod and Z becomes Z+C. X is unchanged. Sums wrap modulo 2^32.
- R5: A control word never produces an output; out_valid stays low in the cycle where it would have left.
- R6: Each data word appears on the outputs exactly NUM_PE clock cycles after the edge that accepted it. Words may arrive on consecutive cycles, and they leave in order, one per cycle.
- R7: Feeding the outputs back through three passes, with control words of 1.0, 2^-4 and 2^-8 (NUM_PE = 4), brings Z within 2^-10 of b/a for a positive divisor a and |b/a| < 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input word present this cycle |
| in_ctrl | input | 1 | Input word is a control word (step size in in_x) |
| in_x | input | 32 | Divisor, or new step size for a control word |
| in_y | input | 32 | Dividend / running remainder |
| in_z | input | 32 | Running quotient |
| out_valid | output | 1 | Output data word present |
| out_x | output | 32 | Divisor passed through |
| out_y | output | 32 | Remainder after the last stage |
| out_z | output | 32 | Quotient estimate after the last stage |

## Verification
Several properties are checked every cycle by assertions. The valid flag advances one stage per edge. X leaves a stage equal to what entered it. A stage's step size holds while no control word passes. A control word leaves each later stage holding half of its neighbour's step.

Other behaviour can only be shown by the bench's scenarios. These cover the direction and arithmetic of each iteration, including sign and wrap cases. They cover the ordering between data and control words in back-to-back streams, the removal of control words from the output, and convergence of the quotient across recirculated passes. The reference model checks all of these against the outputs on every clock.

// File: rtl/cordic_div_pkg.sv
package cordic_div_pkg;
  parameter int unsigned DATA_W = 32;
  parameter int unsigned FRAC_W = 24;

  typedef logic signed [DATA_W-1:0] word_t;

  // one pipeline slot: flags plus the three working values
  typedef struct packed {
    logic  valid;
    logic  ctrl;
    word_t x;
    word_t y;
    word_t z;
  } lane_t;

  localparam word_t STEP_ONE = word_t'(1) <<< FRAC_W;
endpackage

// File: rtl/cordic_div_step.sv
module cordic_div_step
  import cordic_div_pkg::*;
(
  input  word_t x_i,
  input  word_t y_i,
  input  word_t z_i,
  input  word_t c_i,
  output word_t y_o,
  output word_t z_o
);
  localparam int unsigned PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] prod_full;
  word_t                    prod;
  logic                     y_neg;

  always_comb begin
    prod_full = {{DATA_W{x_i[DATA_W-1]}}, x_i} * {{DATA_W{c_i[DATA_W-1]}}, c_i};
    prod      = word_t'(prod_full >>> FRAC_W);
    y_neg     = y_i[DATA_W-1];
    if (y_neg) begin
      y_o = y_i + prod;
      z_o = z_i - c_i;
    end else begin
      y_o = y_i - prod;
      z_o = z_i + c_i;
    end
  end
endmodule

// File: rtl/cordic_div_pe.sv
module cordic_div_pe
  import cordic_div_pkg::*;
#(
  parameter int unsigned IDX = 0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  lane_t lane_i,
  input  word_t c_src,
  output lane_t lane_o,
  output word_t c_q
);
  localparam word_t C_RST = STEP_ONE >>> IDX;

  word_t c_load;
  word_t c_d;
  logic  c_en;
  logic  d_en;
  word_t y_n;
  word_t z_n;

  logic  valid_q, valid_d;
  logic  ctrl_q, ctrl_d;
  word_t x_q, y_q, z_q;

  // first stage takes the loaded value as is, later ones halve it
  generate
    if (IDX == 0) begin : g_head
      assign c_load = c_src;
    end else begin : g_tail
      assign c_load = c_src >>> 1;
    end
  endgenerate

  cordic_div_step u_step (
    .x_i (lane_i.x),
    .y_i (lane_i.y),
    .z_i (lane_i.z),
    .c_i (c_q),
    .y_o (y_n),
    .z_o (z_n)
  );

  // next-state
  always_comb begin
    c_en    = lane_i.valid & lane_i.ctrl;
    d_en    = lane_i.valid & ~lane_i.ctrl;
    c_d     = c_en ? c_load : c_q;
    valid_d = lane_i.valid;
    ctrl_d  = lane_i.valid & lane_i.ctrl;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ctrl_q  <= 1'b0;
      c_q     <= C_RST;
    end else begin
      valid_q <= valid_d;
      ctrl_q  <= ctrl_d;
      if (c_en) c_q <= c_d;
    end
  end

  // datapath registers, enabled by data words only
  always_ff @(posedge clk) begin
    if (d_en) begin
      x_q <= lane_i.x;
      y_q <= y_n;
      z_q <= z_n;
    end
  end

  always_comb begin
    lane_o.valid = valid_q;
    lane_o.ctrl  = ctrl_q;
    lane_o.x     = x_q;
    lane_o.y     = y_q;
    lane_o.z     = z_q;
  end

  assert_valid_travels_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lane_o.valid == $past(lane_i.valid)));

  assert_x_unchanged_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_i.valid && !lane_i.ctrl) |=> (lane_o.x == $past(lane_i.x)));

  assert_step_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(lane_i.valid && lane_i.ctrl) |=> $stable(c_q));
endmodule

// File: rtl/cordic_div_pipe.sv
module cordic_div_pipe
  import cordic_div_pkg::*;
#(
  parameter int unsigned NUM_PE = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_ctrl,
  input  logic signed [DATA_W-1:0] in_x,
  input  logic signed [DATA_W-1:0] in_y,
  input  logic signed [DATA_W-1:0] in_z,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_x,
  output logic signed [DATA_W-1:0] out_y,
  output logic signed [DATA_W-1:0] out_z
);
  localparam int unsigned LAST = NUM_PE;

  lane_t stage_lane [0:LAST];
  word_t stage_c    [0:NUM_PE-1];
  word_t stage_src  [0:NUM_PE-1];

  always_comb begin
    stage_lane[0].valid = in_valid;
    stage_lane[0].ctrl  = in_ctrl;
    stage_lane[0].x     = in_x;
    stage_lane[0].y     = in_y;
    stage_lane[0].z     = in_z;
  end

  generate
    for (genvar k = 0; k < NUM_PE; k++) begin : g_pe
      if (k == 0) begin : g_src0
        assign stage_src[k] = in_x;
      end else begin : g_srcn
        assign stage_src[k] = stage_c[k-1];

        assert_step_halved_R2: assert property (@(posedge clk) disable iff (!rst_n)
          (stage_lane[k].valid && stage_lane[k].ctrl)
            |=> (stage_c[k] == ($past(stage_c[k-1]) >>> 1)));
      end

      cordic_div_pe #(.IDX(k)) u_pe (
        .clk    (clk),
        .rst_n  (rst_n),
        .lane_i (stage_lane[k]),
        .c_src  (stage_src[k]),
        .lane_o (stage_lane[k+1]),
        .c_q    (stage_c[k])
      );
    end
  endgenerate

  // control words are consumed inside the pipeline
  always_comb begin
    out_valid = stage_lane[LAST].valid & ~stage_lane[LAST].ctrl;
    out_x     = stage_lane[LAST].x;
    out_y     = stage_lane[LAST].y;
    out_z     = stage_lane[LAST].z;
  end
endmodule

// File: tb/tb_cordic_div_pipe.sv
module tb_cordic_div_pipe;
  localparam int NPE  = 4;
  localparam int FRAC = 24;
  localparam int ONE  = 1 << FRAC;

  logic clk, rst_n, in_valid, in_ctrl;
  logic signed [31:0] in_x, in_y, in_z, out_x, out_y, out_z;
  logic out_valid;

  cordic_div_pipe #(.NUM_PE(NPE)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctrl(in_ctrl),
    .in_x(in_x), .in_y(in_y), .in_z(in_z),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_z(out_z)
  );

  typedef struct { int due; int x; int y; int z; } exp_t;

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  int    cm [NPE];
  exp_t  expq [$];
  int    cap_x [$], cap_y [$], cap_z [$];
  string cur_req = "R1";

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic void model_run(inout int x, inout int y, inout int z);
    for (int k = 0; k < NPE; k++) begin
      int prod;
      prod = int'((longint'(x) * longint'(cm[k])) >>> FRAC);
      if (y < 0) begin y = y + prod; z = z - cm[k]; end
      else       begin y = y - prod; z = z + cm[k]; end
    end
  endfunction

  task automatic send_ctrl(input int c0);
    @(negedge clk);
    in_valid = 1'b1; in_ctrl = 1'b1; in_x = c0; in_y = 0; in_z = 0;
    for (int k = 0; k < NPE; k++) cm[k] = c0 >>> k;
  endtask

  task automatic send_data(input int x, input int y, input int z);
    exp_t e;
    int ex, ey, ez;
    @(negedge clk);
    in_valid = 1'b1; in_ctrl = 1'b0; in_x = x; in_y = y; in_z = z;
    ex = x; ey = y; ez = z;
    model_run(ex, ey, ez);
    e.due = cyc + NPE; e.x = ex; e.y = ey; e.z = ez;
    expq.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_ctrl = 1'b0;
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (expq.size() > 0 && expq[0].due == cyc) begin
        exp_t e;
        e = expq.pop_front();
        if (!out_valid || out_x !== e.x || out_y !== e.y || out_z !== e.z) begin
          failures++;
          $display("FAIL %s R6 R4: valid=%0b x=%h y=%h z=%h expected valid=1 x=%h y=%h z=%h",
                   cur_req, out_valid, out_x, out_y, out_z, e.x, e.y, e.z);
        end
      end else if (out_valid) begin
        failures++;
        $display("FAIL %s R5 R6: out_valid=1 expected 0", cur_req);
      end
      if (out_valid) begin
        cap_x.push_back(out_x); cap_y.push_back(out_y); cap_z.push_back(out_z);
      end
    end
  end

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic recirc_case(input real a, input real b);
    int   px, py, pz, q_exp, diff;
    cap_x.delete(); cap_y.delete(); cap_z.delete();
    send_ctrl(ONE);
    send_data($rtoi(a * ONE), $rtoi(b * ONE), 0);
    idle(NPE + 1);
    for (int p = 1; p < 3; p++) begin
      px = cap_x[0]; py = cap_y[0]; pz = cap_z[0];
      cap_x.delete(); cap_y.delete(); cap_z.delete();
      send_ctrl(ONE >>> (NPE * p));
      send_data(px, py, pz);
      idle(NPE + 1);
    end
    q_exp = $rtoi(b / a * ONE);
    diff  = cap_z[0] - q_exp;
    if (diff < 0) diff = -diff;
    checks++;
    if (diff > (ONE >>> 10)) begin
      failures++;
      $display("FAIL R7: z=%h expected %h within %h", cap_z[0], q_exp, ONE >>> 10);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_ctrl = 1'b0; in_x = 0; in_y = 0; in_z = 0;
    for (int k = 0; k < NPE; k++) cm[k] = ONE >>> k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: nothing valid after reset
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1: out_valid=%b expected 0", out_valid);
    end
    // R1: default step schedule without any control word
    cur_req = "R1";
    send_data(2 * ONE, ONE, 0);
    send_data(ONE, -(ONE / 2), 0);
    idle(NPE + 2);

    // R2: loaded step sizes, including a non power of two, back-to-back data (R6)
    cur_req = "R2";
    send_ctrl(ONE / 2);
    send_data(3 * ONE, ONE, 0);
    send_data(ONE, ONE / 3, 0);
    send_ctrl(32'h00C0_0000);
    for (int i = 0; i < 5; i++) send_data(ONE + i * 1000, ONE / 4 - i * 77777, i);
    idle(NPE + 2);

    // R3: data and control words interleaved
    cur_req = "R3";
    send_data(2 * ONE, ONE, 0);
    send_ctrl(ONE / 8);
    send_data(2 * ONE, ONE, 0);
    send_ctrl(ONE);
    send_data(2 * ONE, ONE, 0);
    send_data(ONE, -ONE, 5);
    idle(NPE + 2);

    // R5: control-only stream leaves nothing on the output
    cur_req = "R5";
    for (int i = 0; i < 6; i++) send_ctrl(ONE >>> i);
    idle(NPE + 2);

    // R4: sign corners, negative divisor, zero remainder, wrap
    cur_req = "R4";
    send_ctrl(ONE);
    send_data(-2 * ONE, ONE, 0);
    send_data(ONE, 0, 0);
    send_data(32'h7FFF_0000, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    send_data(32'h8000_0000, 32'h8000_0000, 0);
    idle(NPE + 2);

    // R7: recirculated passes converge toward b/a
    cur_req = "R7";
    recirc_case(2.0, 1.0);
    recirc_case(3.0, 1.0);
    recirc_case(1.5, -1.2);
    recirc_case(4.0, 3.0);
    idle(4);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule